// File: doc/BRIEF.md
# Converter Sample FIFO with Status/Control Register

This block sits between an analog-to-digital converter and a host bus. Each time the converter signals end of conversion, the block stores the 12-bit result and an out-of-range tag in an eight-deep FIFO. Data moves down toward location 0, so location 0 always holds the oldest stored word. The host shares one 12-bit data path for two targets. With `sel_reg` low, a read returns the head sample and removes it. With `sel_reg` high, the host reads the status word or writes the control fields.

The control fields hold a 3-bit almost-full threshold, a bit that disables the almost-full flag, and a bit that lets the data drivers turn on while the converter is busy. A write with the reset bit set clears the block. The status word reports the following: the active-low almost-full flag, a sticky overrun flag, an any-sample out-of-range flag, a head-sample out-of-range flag, an empty flag, and a count field that gives the highest valid location index.

Occupancy is tracked by a three-state controller:
- EMPTY goes to PART on *first_in* (a conversion).
- PART goes to FULL on *fill* (a conversion without a read at seven words).
- PART goes to EMPTY on *drain* (a read without a conversion at one word).
- FULL goes to PART on *unload* (a read without a conversion).
- FULL stays in FULL on *swap* (read and conversion in the same cycle) and on *spill* (a conversion without a read, whose result is dropped).
- A soft or hard reset returns any state to EMPTY.

Top module: `smpl_fifo_stat`

## Requirements
- R1: After reset the FIFO is empty, the threshold is 000, the almost-full disable is 1, the bus gate is off (drivers allowed), and overrun is 0. The status word then reads 0x890. Its layout is: [11] almost-full (active low), [10:8] threshold, [7] disable, [6] overrun, [5] any out-of-range, [4] empty, [3] head out-of-range, [2:0] count.
- R2: Samples are read back in the order they were converted. A data read (`sel_reg`=0) returns location 0 and moves the remaining words down one place.
- R3: The count field [2:0] equals the number of stored words minus one. It reads 000 both for one word (empty bit 0) and for no word (empty bit [4] = 1).
- R4: The almost-full flag is evaluated only on a conversion. It asserts when the stored word count after that conversion equals the threshold plus one. Reads and threshold writes do not change it between conversions.
- R5: While the disable bit (write bit [7]) is 1, `afull_n` and status bit [11] read 1.
- R6: A conversion that arrives with eight words stored and no read in the same cycle is dropped. It also sets overrun, bit [6], which stays set until reset.
- R7: A register write with bit [6] = 1 has the same effect as the reset input, whatever the other written bits are.
- R8: Status bit [5] is 1 when any stored word carries the out-of-range tag. Bit [3] is 1 when the word in location 0 carries it.
- R9: With the write field bit [5] at 0 and `busy_n` low, `rdata_oe` stays 0 and a data read removes nothing. With bit [5] at 1, or with `busy_n` high, a read drives the bus.
- R10: A data read from an empty FIFO returns the last word read again and changes no state.
- R11: A status read moves no FIFO data and leaves the count unchanged.
- R12: A read and a conversion in the same cycle with eight words stored pop the head and append the new sample. The count stays at eight and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvt_done | input | 1 | End-of-conversion strobe, one cycle per sample |
| cvt_data | input | 12 | Conversion result |
| cvt_oor | input | 1 | Out-of-range tag of the result |
| sel_reg | input | 1 | 0 selects FIFO data, 1 selects the status/control register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (register only) |
| wdata | input | 12 | Write data |
| busy_n | input | 1 | Converter busy, active low |
| rdata | output | 12 | Read data: head sample or status word |
| rdata_oe | output | 1 | Bus driver enable for `rdata` |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
The FIFO is exercised in four ways, and each tells a different fault apart:
- Plain ascending fills followed by drains show whether ordering and the count field are right.
- A fill past eight words separates a correct drop-and-flag from an overwrite.
- A combined read and conversion at full shows whether the pop is serviced before the append.
- Reading after the last word has been taken shows whether the head is held or shifted in from stale storage.

Threshold tests then check the following:
- A sequence that crosses the programmed count and continues past it shows that the flag follows the count at each conversion and not at reads.
- Toggling the disable bit with no conversion in between shows the flag's register is separate from its mask.

// File: rtl/sf_pkg.sv
package sf_pkg;
    localparam int SF_DW    = 12;
    localparam int SF_DEPTH = 8;

    // control write field positions (register layout is fixed at 12 bits)
    localparam int B_THR_LO = 8;
    localparam int B_DIS    = 7;
    localparam int B_SRST   = 6;
    localparam int B_OE     = 5;

    typedef struct packed {
        logic             tag;
        logic [SF_DW-1:0] data;
    } sf_entry_t;

    typedef enum logic [1:0] {
        SF_EMPTY = 2'd0,
        SF_PART  = 2'd1,
        SF_FULL  = 2'd2
    } sf_state_t;
endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
    import sf_pkg::*;
#(
    parameter int DEPTH = SF_DEPTH,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nx,
    output logic [CW-1:0] wr_idx,
    output logic          do_push,
    output logic          do_pop,
    output logic          drop,
    output sf_state_t     state
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    sf_state_t st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SF_EMPTY;
            cnt   <= '0;
        end else begin
            state <= st_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx  = state;
        cnt_nx = cnt;
        unique case (state)
            SF_EMPTY: begin
                if (push_req) begin            // first_in
                    st_nx  = SF_PART;
                    cnt_nx = ONE;
                end
            end
            SF_PART: begin
                if (push_req && !pop_req) begin
                    cnt_nx = cnt + ONE;
                    if (cnt == LAST) st_nx = SF_FULL;   // fill
                end else if (pop_req && !push_req) begin
                    cnt_nx = cnt - ONE;
                    if (cnt == ONE) st_nx = SF_EMPTY;   // drain
                end
            end
            SF_FULL: begin
                if (pop_req && !push_req) begin      // unload
                    st_nx  = SF_PART;
                    cnt_nx = cnt - ONE;
                end
            end
            default: begin
                st_nx  = SF_EMPTY;
                cnt_nx = '0;
            end
        endcase
        if (clr) begin
            st_nx  = SF_EMPTY;
            cnt_nx = '0;
        end
    end

    // actions
    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        drop    = 1'b0;
        unique case (state)
            SF_EMPTY: do_push = push_req;
            SF_PART: begin
                do_push = push_req;
                do_pop  = pop_req;
            end
            SF_FULL: begin
                do_pop  = pop_req;
                do_push = push_req && pop_req;   // swap
                drop    = push_req && !pop_req;  // spill
            end
            default: ;
        endcase
        if (clr) begin
            do_push = 1'b0;
            do_pop  = 1'b0;
            drop    = 1'b0;
        end
        wr_idx = do_pop ? (cnt - ONE) : cnt;
    end
endmodule

// File: rtl/sf_store.sv
module sf_store
    import sf_pkg::*;
#(
    parameter int DEPTH = SF_DEPTH,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          do_push,
    input  logic          do_pop,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] wr_idx,
    input  sf_entry_t     din,
    output sf_entry_t     head,
    output logic          any_oor
);
    sf_entry_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        sf_entry_t above;
        if (i < DEPTH - 1) begin : g_up
            assign above = mem[i+1];
        end else begin : g_top
            assign above = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (clr) begin
                mem[i] <= '0;
            end else begin
                // shift only inside the valid region so location 0 is kept on the last pop
                if (do_pop && (CW'(i) + CW'(1) < cnt)) mem[i] <= above;
                if (do_push && (wr_idx == CW'(i)))     mem[i] <= din;
            end
        end
    end

    assign head = mem[0];

    always_comb begin
        any_oor = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt) any_oor = any_oor | mem[i].tag;
        end
    end
endmodule

// File: rtl/sf_regs.sv
module sf_regs
    import sf_pkg::*;
#(
    parameter int DEPTH = SF_DEPTH,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int TW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [SF_DW-1:0] wdata,
    input  logic             cvt_done,
    input  logic             drop,
    input  logic [CW-1:0]    cnt_nx,
    output logic [TW-1:0]    thr,
    output logic             dis_bit,
    output logic             oe_bit,
    output logic             ovr_flag,
    output logic             afl_q
);
    logic [CW-1:0] trip;
    assign trip = {1'b0, thr} + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr      <= '0;
            dis_bit  <= 1'b1;
            oe_bit   <= 1'b1;
            ovr_flag <= 1'b0;
            afl_q    <= 1'b0;
        end else if (clr) begin
            thr      <= '0;
            dis_bit  <= 1'b1;
            oe_bit   <= 1'b1;
            ovr_flag <= 1'b0;
            afl_q    <= 1'b0;
        end else begin
            if (wr) begin
                thr     <= wdata[B_THR_LO +: TW];
                dis_bit <= wdata[B_DIS];
                oe_bit  <= wdata[B_OE];
            end
            if (drop)     ovr_flag <= 1'b1;
            if (cvt_done) afl_q    <= (cnt_nx == trip);
        end
    end
endmodule

// File: rtl/smpl_fifo_stat.sv
module smpl_fifo_stat
    import sf_pkg::*;
#(
    parameter int DEPTH = SF_DEPTH,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int TW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cvt_done,
    input  logic [SF_DW-1:0] cvt_data,
    input  logic             cvt_oor,
    input  logic             sel_reg,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [SF_DW-1:0] wdata,
    input  logic             busy_n,
    output logic [SF_DW-1:0] rdata,
    output logic             rdata_oe,
    output logic             afull_n
);
    logic [CW-1:0] cnt, cnt_nx, wr_idx;
    logic          do_push, do_pop, drop;
    sf_state_t     state;
    sf_entry_t     din, head;
    logic          any_oor;
    logic [TW-1:0] thr;
    logic          dis_bit, oe_bit, ovr_flag, afl_q;
    logic          soft_rst, pop_req, reg_wr;
    logic [TW-1:0] cnt_fld;
    logic [SF_DW-1:0] status;

    assign reg_wr   = wr_en && sel_reg;
    assign soft_rst = reg_wr && wdata[B_SRST];
    assign rdata_oe = rd_en && (oe_bit || busy_n);
    assign pop_req  = rd_en && !sel_reg && rdata_oe;
    assign din      = '{tag: cvt_oor, data: cvt_data};

    sf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push_req(cvt_done), .pop_req(pop_req),
        .cnt(cnt), .cnt_nx(cnt_nx), .wr_idx(wr_idx),
        .do_push(do_push), .do_pop(do_pop), .drop(drop), .state(state)
    );

    sf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .do_push(do_push), .do_pop(do_pop), .cnt(cnt), .wr_idx(wr_idx),
        .din(din), .head(head), .any_oor(any_oor)
    );

    sf_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr(reg_wr), .wdata(wdata),
        .cvt_done(cvt_done), .drop(drop), .cnt_nx(cnt_nx),
        .thr(thr), .dis_bit(dis_bit), .oe_bit(oe_bit),
        .ovr_flag(ovr_flag), .afl_q(afl_q)
    );

    assign afull_n = !(afl_q && !dis_bit);
    assign cnt_fld = (cnt == '0) ? '0 : TW'(cnt - CW'(1));
    assign status  = {afull_n, thr, dis_bit, ovr_flag, any_oor,
                      (state == SF_EMPTY), (cnt != '0) && head.tag, cnt_fld};
    assign rdata   = sel_reg ? status : head.data;
endmodule

// File: rtl/sf_chk.sv
module sf_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cvt_done,
    input logic          rd_en,
    input logic          wr_en,
    input logic          sel_reg,
    input logic          busy_n,
    input logic          rdata_oe,
    input logic          afull_n,
    input logic [CW-1:0] cnt,
    input logic          ovr_flag,
    input logic          oe_bit,
    input logic          dis_bit,
    input logic          soft_rst,
    input logic          pop
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R4
    afl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cvt_done && !wr_en) |=> $stable(afull_n));

    // R5
    dis_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_bit |-> afull_n);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !soft_rst) |=> ovr_flag);

    // R9
    bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_bit && !busy_n) |-> !rdata_oe);

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel_reg && cnt == '0 && !cvt_done && !soft_rst) |=> (cnt == '0));

    // R11
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_reg && !cvt_done && !wr_en) |=> $stable(cnt));

    // R12
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && cvt_done && pop && !ovr_flag && !soft_rst)
            |=> (cnt == FULL && !ovr_flag));
endmodule

bind smpl_fifo_stat sf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cvt_done(cvt_done), .rd_en(rd_en),
    .wr_en(wr_en), .sel_reg(sel_reg), .busy_n(busy_n), .rdata_oe(rdata_oe),
    .afull_n(afull_n), .cnt(cnt), .ovr_flag(ovr_flag), .oe_bit(oe_bit),
    .dis_bit(dis_bit), .soft_rst(soft_rst), .pop(pop_req)
);

// File: tb/smpl_fifo_stat_test.sv
module smpl_fifo_stat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cvt_done = 1'b0;
    logic [11:0] cvt_data = '0;
    logic        cvt_oor = 1'b0;
    logic        sel_reg = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wdata = '0;
    logic        busy_n = 1'b1;
    logic [11:0] rdata;
    logic        rdata_oe;
    logic        afull_n;

    int compared = 0;
    int mismatched = 0;
    logic [11:0] sb[$];
    logic [11:0] last_word;

    smpl_fifo_stat uut (
        .clk(clk), .rst_n(rst_n), .cvt_done(cvt_done), .cvt_data(cvt_data),
        .cvt_oor(cvt_oor), .sel_reg(sel_reg), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .busy_n(busy_n), .rdata(rdata), .rdata_oe(rdata_oe),
        .afull_n(afull_n)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: conversion; scoreboard keeps what should be stored
    task automatic convert(logic [11:0] d, logic oor);
        @(negedge clk);
        cvt_done = 1'b1; cvt_data = d; cvt_oor = oor;
        @(posedge clk); #1;
        cvt_done = 1'b0;
        if (sb.size() < 8) sb.push_back(d);
    endtask

    task automatic reg_write(logic [11:0] v);
        @(negedge clk);
        sel_reg = 1'b1; wr_en = 1'b1; wdata = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic stat_read(string req, logic [11:0] exp);
        @(negedge clk);
        sel_reg = 1'b1; rd_en = 1'b1; busy_n = 1'b1;
        #2;
        check(req, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // monitor side: read a sample and compare with scoreboard head
    task automatic data_read(string req);
        logic [11:0] exp;
        @(negedge clk);
        sel_reg = 1'b0; rd_en = 1'b1;
        #2;
        exp = (sb.size() > 0) ? sb.pop_front() : last_word;
        check(req, rdata, exp);
        check(req, {11'd0, rdata_oe}, 12'd1);
        last_word = exp;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic swap(string req, logic [11:0] d);
        logic [11:0] exp;
        @(negedge clk);
        sel_reg = 1'b0; rd_en = 1'b1; cvt_done = 1'b1; cvt_data = d; cvt_oor = 1'b0;
        #2;
        exp = sb.pop_front();
        check(req, rdata, exp);
        sb.push_back(d);
        @(posedge clk); #1;
        rd_en = 1'b0; cvt_done = 1'b0;
    endtask

    initial begin
        #4ms;
        mismatched++; compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        last_word = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        stat_read("R1 reset status", 12'h890);
        check("R1 afull_n after reset", {11'd0, afull_n}, 12'd1);

        // threshold 3, flag enabled, drivers allowed
        reg_write(12'h320);
        stat_read("R4 config readback", 12'hB10);
        for (int i = 1; i <= 3; i++) convert(12'h100 + 12'(i), 1'b0);
        check("R4 below threshold", {11'd0, afull_n}, 12'd1);
        convert(12'h104, 1'b1);
        check("R4 at threshold", {11'd0, afull_n}, 12'd0);
        stat_read("R8 R3 status four words", 12'h323);

        data_read("R2 first out");
        check("R4 read does not release", {11'd0, afull_n}, 12'd0);
        stat_read("R11 status read one", 12'h322);
        stat_read("R11 status read two", 12'h322);

        // R6 overflow
        for (int i = 5; i <= 9; i++) convert(12'h100 + 12'(i), 1'b0);
        check("R4 past threshold", {11'd0, afull_n}, 12'd1);
        convert(12'h1AA, 1'b0);
        stat_read("R6 overrun status", 12'hB67);
        convert(12'h1AB, 1'b0);
        stat_read("R6 overrun sticky", 12'hB67);

        // R7 soft reset with other bits set
        reg_write(12'h3E0);
        sb.delete();
        stat_read("R7 soft reset status", 12'h890);

        // R5 disable masks flag
        reg_write(12'h0A0);
        convert(12'h2C1, 1'b0);
        check("R5 disabled flag high", {11'd0, afull_n}, 12'd1);
        reg_write(12'h020);
        check("R4 unmask shows held flag", {11'd0, afull_n}, 12'd0);
        stat_read("R3 one word count", 12'h000);

        // R10 empty read returns last word
        data_read("R2 single word");
        stat_read("R3 empty status", 12'h010);
        data_read("R10 empty repeat");
        stat_read("R10 state unchanged", 12'h010);

        // R12 swap at full
        for (int i = 0; i < 8; i++) convert(12'h300 + 12'(i), 1'b0);
        stat_read("R12 full status", 12'h807);
        swap("R12 swap head", 12'h3F0);
        stat_read("R12 no overrun", 12'h807);
        for (int i = 0; i < 8; i++) data_read("R2 drain order");

        // R9 bus gating while busy
        reg_write(12'h000);
        convert(12'h4A5, 1'b0);
        @(negedge clk);
        sel_reg = 1'b0; busy_n = 1'b0; rd_en = 1'b1;
        #2;
        check("R9 gated oe", {11'd0, rdata_oe}, 12'd0);
        @(posedge clk); #1;
        rd_en = 1'b0; busy_n = 1'b1;
        stat_read("R9 gated read kept word", 12'h000);
        reg_write(12'h020);
        @(negedge clk);
        sel_reg = 1'b0; busy_n = 1'b0; rd_en = 1'b1;
        #2;
        check("R9 ungated oe", {11'd0, rdata_oe}, 12'd1);
        check("R9 ungated data", rdata, 12'h4A5);
        @(posedge clk); #1;
        rd_en = 1'b0; busy_n = 1'b1;
        stat_read("R9 word removed", 12'h010);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule